// File: doc/BRIEF.md
# Countdown Event Timer with Register Access

A single-channel event timer reached through a simple APB-style register port. Software places a 64-bit reload value in two 32-bit words, then writes a control word that starts the counter, picks auto-reload or single-shot behaviour, and unmasks the interrupt. The counter moves down by one on every cycle where the `tick` input is high. When it expires, a sticky status flag is set, and the interrupt line follows that flag while the interrupt is unmasked.

The usual sequence is to stop the timer, write the reload words, and then write the control word with the enable bit set. The reload value is taken in on the rising edge of the enable bit. A reload of N-1 gives one expiry every N ticks. Two register-map variants are supported, and they differ only in where the control word sits. An elaboration parameter chooses between them.

Top module: `evt_timer`

## Requirements
- R1: The reload low word is at offset 0x00 and the high word is at offset 0x04. Both are read/write and read back what was last written.
- R2: The control word is at 0x10 when MAP_VARIANT=0 and at 0x1C when MAP_VARIANT=1. Bit 0 is enable, bit 1 is mode (1 = single-shot), and bit 2 is interrupt unmask. Only these three bits are stored, and the other bits read as 0.
- R3: A 0-to-1 change of the enable bit loads the full reload value one cycle after the control write. A tick in that load cycle is not counted.
- R4: In auto-reload mode with a reload of N-1, expiries come every N ticks. The counter reloads on the tick on which it expires.
- R5: In single-shot mode there is one expiry. After it the counter holds and does not expire again until enable is cleared and then set again.
- R6: Bit 0 of offset 0x18 is the status flag. Writing 1 to that bit clears it. Writing 0 leaves it unchanged.
- R7: An expiry in the same cycle as a clearing write leaves the status flag set.
- R8: `irq` is high exactly when both the status flag and the unmask bit are set. An expiry while masked still sets the status flag.
- R9: After 0 is written to the control word, ticks cause no expiry.
- R10: Offsets that are not mapped read as 0, and writes to them change nothing.
- R11: The high reload word takes part in the count. A reload of 2^32 does not expire within a few ticks.
- R12: After reset, every register reads 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| psel | input | 1 | Register select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W (8) | Byte offset |
| pwdata | input | DATA_W (32) | Write data |
| prdata | output | DATA_W (32) | Read data, valid while selected |
| tick | input | 1 | Count enable, one decrement per high cycle |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is the collision between an expiry and a clearing write to the status flag. Both must land on the same clock edge, and the status flag must still end up set. The stimulus makes this collision certain by using a reload of 0 in auto-reload mode, so that every tick expires. It then raises `tick` during the access phase of the clearing write. A second hard case is the tick that falls on the load cycle itself. The stimulus drives a tick on the edge that follows the enabling write and then checks that the expiry still needs a full N further ticks.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

   // Register offsets that software depends on
   localparam int unsigned OFF_RELOAD_BASE = 'h00;
   localparam int unsigned OFF_STATUS      = 'h18;
   localparam int unsigned OFF_CTRL_MAP0   = 'h10;
   localparam int unsigned OFF_CTRL_MAP1   = 'h1C;

   typedef struct packed {
      logic unmask;   // bit 2
      logic oneshot;  // bit 1
      logic en;       // bit 0
   } ctrl_t;

   localparam int unsigned CTRL_BITS = $bits(ctrl_t);

endpackage

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
   import evt_timer_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned CNT_W    = 64,
   parameter int unsigned CTRL_OFF = OFF_CTRL_MAP0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              expire,
   output logic [DATA_W-1:0] rdata,
   output logic [CNT_W-1:0]  reload,
   output ctrl_t             ctrl,
   output logic              status
);

   localparam int unsigned NWORDS = CNT_W / DATA_W;
   localparam int unsigned BYTES  = DATA_W / 8;
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFF);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STATUS);

   logic stat_clr;
   assign stat_clr = wr_en && (addr == A_STAT) && wdata[0];

   // Reload words, one register per word of the count
   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      localparam logic [ADDR_W-1:0] A_W = ADDR_W'(OFF_RELOAD_BASE + w * BYTES);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            reload[w*DATA_W +: DATA_W] <= '0;
         else if (wr_en && addr == A_W)
            reload[w*DATA_W +: DATA_W] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl <= '0;
      else if (wr_en && addr == A_CTRL)
         ctrl <= ctrl_t'(wdata[CTRL_BITS-1:0]);
   end

   // Sticky flag: a fresh expiry beats a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         status <= 1'b0;
      else if (expire)
         status <= 1'b1;
      else if (stat_clr)
         status <= 1'b0;
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         for (int w = 0; w < NWORDS; w++)
            if (addr == ADDR_W'(OFF_RELOAD_BASE + w * BYTES))
               rdata = reload[w*DATA_W +: DATA_W];
         if (addr == A_CTRL)
            rdata = DATA_W'(ctrl);
         if (addr == A_STAT)
            rdata = DATA_W'(status);
      end
   end

   a_r7_expire_wins: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> status);
   a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr && !expire) |=> !status);
   a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (status && !stat_clr) |=> status);

endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core #(
   parameter int unsigned CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             en,
   input  logic             oneshot,
   input  logic [CNT_W-1:0] reload,
   output logic             expire
);

   logic [CNT_W-1:0] cnt;
   logic             en_q;
   logic             done;
   logic             load;
   logic             run;
   logic             at_zero;

   assign load    = en && !en_q;
   assign run     = en && en_q && !done;
   assign at_zero = (cnt == '0);
   assign expire  = run && tick && at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
         done <= 1'b0;
         cnt  <= '0;
      end else begin
         en_q <= en;
         if (load) begin
            cnt  <= reload;
            done <= 1'b0;
         end else if (run && tick) begin
            if (!at_zero)
               cnt <= cnt - 1'b1;
            else if (oneshot)
               done <= 1'b1;
            else
               cnt <= reload;
         end
      end
   end

   a_r3_load_takes_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !en_q) |=> (cnt == $past(reload)));
   a_r4_one_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick && !at_zero) |=> (cnt == $past(cnt) - 1'b1));
   a_r5_holds_after_shot: assert property (@(posedge clk) disable iff (!rst_n)
      (done && en && en_q) |=> $stable(cnt));
   a_r3_no_count_at_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !expire);

endmodule

// File: rtl/evt_timer.sv
module evt_timer
   import evt_timer_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned CNT_W       = 64,
   parameter int unsigned MAP_VARIANT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   input  logic              tick,
   output logic              irq
);

   localparam int unsigned CTRL_OFF = (MAP_VARIANT == 0) ? OFF_CTRL_MAP0 : OFF_CTRL_MAP1;

   if (MAP_VARIANT > 1) begin : g_bad_variant
      $error("MAP_VARIANT must be 0 or 1");
   end
   if (DATA_W % 8 != 0 || CNT_W % DATA_W != 0) begin : g_bad_width
      $error("CNT_W must be a multiple of DATA_W, DATA_W of 8");
   end
   if ((1 << ADDR_W) <= OFF_CTRL_MAP1) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic             wr_en, rd_en, expire, status;
   logic [CNT_W-1:0] reload;
   ctrl_t            ctrl;

   assign wr_en = psel && penable && pwrite;
   assign rd_en = psel && !pwrite;

   evt_timer_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CTRL_OFF(CTRL_OFF)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .addr(paddr), .wdata(pwdata), .expire(expire),
      .rdata(prdata), .reload(reload), .ctrl(ctrl), .status(status)
   );

   evt_timer_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(ctrl.en),
      .oneshot(ctrl.oneshot), .reload(reload), .expire(expire)
   );

   assign irq = status && ctrl.unmask;

   a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.unmask |-> !irq);
   a_r9_stopped_no_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl.en && !status) |=> !status);
   a_r12_irq_needs_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      (!status && !expire) |=> !irq);

endmodule

// File: tb/evt_timer_bench.sv
module evt_timer_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0, tick = 1'b0;
   logic [7:0]  paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit summary_done = 0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #10 clk = ~clk;   // 50 MHz

   evt_timer u_evt_timer (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .tick(tick), .irq(irq)
   );

   // Monitor: compares each read against the queued expectation
   always @(negedge clk) begin
      if (psel && penable && !pwrite && exp_q.size() > 0) begin
         logic [31:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (prdata !== e) begin
            errors++;
            $display("FAIL %s read got %h expected %h", t, prdata, e);
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit with_tick = 0);
      psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
      @(posedge clk); #1;
      penable = 1; tick = with_tick;
      @(posedge clk); #1;
      psel = 0; penable = 0; pwrite = 0; tick = 0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
      exp_q.push_back(e); tag_q.push_back(t);
      psel = 1; penable = 0; pwrite = 0; paddr = a;
      @(posedge clk); #1;
      penable = 1;
      @(posedge clk); #1;
      psel = 0; penable = 0;
   endtask

   task automatic ticks(input int n);
      repeat (n) begin tick = 1; @(posedge clk); #1; tick = 0; end
   endtask

   task automatic chk_irq(input logic e, input string t);
      @(negedge clk);
      checks++;
      if (irq !== e) begin
         errors++;
         $display("FAIL %s irq got %b expected %b", t, irq, e);
      end
      @(posedge clk); #1;
   endtask

   task automatic finish_run();
      if (!summary_done) begin
         summary_done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 20);
      checks++; errors++;
      $display("FAIL watchdog expired got hang expected completion");
      finish_run();
   end

   initial begin
      idle(3);
      rst_n = 1;
      idle(1);
      // R12 reset state
      chk_irq(0, "R12");
      rd(8'h00, 32'h0, "R12");
      rd(8'h04, 32'h0, "R12");
      rd(8'h10, 32'h0, "R12");
      rd(8'h18, 32'h0, "R12");

      // R1 / R2 readback
      wr(8'h00, 32'hDEADBEEF); wr(8'h04, 32'h12345678);
      rd(8'h00, 32'hDEADBEEF, "R1");
      rd(8'h04, 32'h12345678, "R1");
      wr(8'h10, 32'hFFFF_FFF8);
      rd(8'h10, 32'h0, "R2");
      wr(8'h10, 32'h0000_0006);
      rd(8'h10, 32'h6, "R2");
      rd(8'h1C, 32'h0, "R2");
      wr(8'h10, 32'h0);

      // R10 unmapped offsets
      wr(8'h08, 32'hFFFF_FFFF);
      wr(8'h1C, 32'hFFFF_FFFF);
      rd(8'h08, 32'h0, "R10");
      rd(8'h1C, 32'h0, "R10");
      rd(8'h00, 32'hDEADBEEF, "R10");
      rd(8'h10, 32'h0, "R10");

      // R4 auto-reload period N=4
      wr(8'h00, 32'd3); wr(8'h04, 32'd0);
      wr(8'h10, 32'h5); idle(1);
      ticks(3); chk_irq(0, "R4");
      ticks(1); chk_irq(1, "R4");
      wr(8'h18, 32'h0); chk_irq(1, "R6");
      wr(8'h18, 32'h1); chk_irq(0, "R6");
      ticks(3); chk_irq(0, "R4");
      ticks(1); chk_irq(1, "R4");
      wr(8'h18, 32'h1);

      // R8 masked expiry still sets status
      wr(8'h10, 32'h0); wr(8'h10, 32'h1); idle(1);
      ticks(4); chk_irq(0, "R8");
      rd(8'h18, 32'h1, "R8");
      wr(8'h10, 32'h5); chk_irq(1, "R8");
      wr(8'h18, 32'h1);

      // R9 stop
      wr(8'h10, 32'h0);
      ticks(8);
      rd(8'h18, 32'h0, "R9");

      // R5 single-shot
      wr(8'h00, 32'd1);
      wr(8'h10, 32'h7); idle(1);
      ticks(1); chk_irq(0, "R5");
      ticks(1); chk_irq(1, "R5");
      wr(8'h18, 32'h1);
      ticks(6);
      rd(8'h18, 32'h0, "R5");
      wr(8'h10, 32'h0); wr(8'h10, 32'h7); idle(1);
      ticks(2); chk_irq(1, "R5");
      wr(8'h18, 32'h1);

      // R3 tick on the load cycle is ignored
      wr(8'h10, 32'h0);
      wr(8'h00, 32'd2);
      wr(8'h10, 32'h5);
      ticks(1);
      ticks(2); chk_irq(0, "R3");
      ticks(1); chk_irq(1, "R3");
      wr(8'h10, 32'h0); wr(8'h18, 32'h1);

      // R7 expiry beats clear in the same cycle
      wr(8'h00, 32'd0);
      wr(8'h10, 32'h5); idle(1);
      ticks(1); chk_irq(1, "R7");
      wr(8'h18, 32'h1, 1); chk_irq(1, "R7");
      wr(8'h18, 32'h1); chk_irq(0, "R7");
      wr(8'h10, 32'h0);

      // R11 high word counts
      wr(8'h00, 32'd0); wr(8'h04, 32'd1);
      wr(8'h10, 32'h5); idle(1);
      ticks(3); chk_irq(0, "R11");
      rd(8'h18, 32'h0, "R11");
      rd(8'h04, 32'h1, "R11");
      wr(8'h10, 32'h0);

      idle(2);
      finish_run();
   end

endmodule